// File: doc/BRIEF.md
# I2C Command/Display-Data Byte Router

This block is the receive-only front end of a display controller on a two-wire serial bus. It samples the clock and data lines with a faster system clock and finds the start and stop conditions. It checks the address byte against a built-in pattern whose lowest bit comes from a strap pin. It pulls the data line low in the acknowledge slot of every byte it accepts. Every byte after the address is either a control byte or a payload byte. The block forwards each payload byte, unchanged, to one of two strobed output ports: one for commands and one for display-memory writes.

The control byte carries two flags. The route flag picks the destination port. The chain flag says whether another control byte comes after the next payload byte, or whether every byte up to the end of the transfer is payload of the chosen kind. Devices that share the same strap level all acknowledge together. This lets several controllers take one broadcast. A device with a different strap level, or a read request, gets no acknowledge and the device stays silent until the next start.

Top module: `i2c_ctl_demux`

## Requirements
- R1: After a start, the address byte is accepted when bits 7:1 equal the parameter `DEV_ADDR` with its bit 0 replaced by `addr_sel_i`, and bit 0 (the direction bit) is 0. The block then drives `sda_pull_o` high for the whole ninth clock of that byte.
- R2: When the address does not match, the block gives no acknowledge and no output strobe for any byte until the next start.
- R3: An address byte whose direction bit is 1 (read) is not acknowledged, and the transfer is ignored as in R2.
- R4: The first byte after an accepted address is a control byte, with chain flag in bit 7 and route flag in bit 6. Bits 5:0 have no effect, and a control byte never appears on an output port.
- R5: Route flag 0 sends the governed payload byte(s) to `cmd_data_o`/`cmd_valid_o`. Route flag 1 sends them to `ram_data_o`/`ram_valid_o`, with the byte value unchanged.
- R6: Chain flag 1 means exactly one payload byte follows, and the byte after it is again a control byte.
- R7: Chain flag 0 means every later byte until a stop or start is payload of the selected kind, whatever its value.
- R8: Inside an accepted transfer, every byte (control or payload) is acknowledged in its ninth clock.
- R9: Each output strobe lasts exactly one system clock cycle, and the two strobes are never high together. After reset both strobes and `sda_pull_o` are low.
- R10: A start or repeated start seen anywhere makes the next byte an address byte again, followed by a control byte.
- R11: After a stop, no byte is acknowledged and no strobe appears until a new start.
- R12: Except in reaction to a start or a stop, `sda_pull_o` only changes while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Strap level that replaces the address pattern's lowest bit |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| cmd_valid_o | output | 1 | One-cycle strobe for a command byte |
| cmd_data_o | output | 8 | Command byte, valid with the strobe |
| ram_valid_o | output | 1 | One-cycle strobe for a display-data byte |
| ram_data_o | output | 8 | Display-data byte, valid with the strobe |

## Verification
The bench builds the block with `DEV_ADDR` set to 7'h39, so the pattern's own lowest bit is 1. With the strap at 0 the accepted address is 7'h38 (byte 0x70), and with the strap at 1 it is 7'h39 (byte 0x72). Byte 0x70 is therefore accepted or refused depending only on the strap, which shows the strap really replaces the lowest bit. The synchroniser is left at its default two stages, and the serial clock is slow enough that the acknowledge can be sampled in the middle of the ninth high phase.

// File: rtl/i2c_demux_pkg.sv
package i2c_demux_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BCNT_W  = $clog2(BYTE_W);
  localparam int unsigned CHAIN_B = 7;
  localparam int unsigned ROUTE_B = 6;

  typedef enum logic [1:0] {
    LNK_IDLE,
    LNK_RX,
    LNK_ACK_SETUP,
    LNK_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    RT_CTRL,
    RT_SINGLE,
    RT_STREAM
  } route_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ch;
  logic [STAGES-1:0] sda_ch;
  logic              scl_prev_q;
  logic              sda_prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic scl_d, sda_d;
    if (g == 0) begin : g_first
      assign scl_d = scl_i;
      assign sda_d = sda_i;
    end else begin : g_next
      assign scl_d = scl_ch[g-1];
      assign sda_d = sda_ch[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_ch[g] <= 1'b1;
        sda_ch[g] <= 1'b1;
      end else begin
        scl_ch[g] <= scl_d;
        sda_ch[g] <= sda_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_ch[STAGES-1];
      sda_prev_q <= sda_ch[STAGES-1];
    end
  end

  assign scl_o      = scl_ch[STAGES-1];
  assign sda_o      = sda_ch[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/i2c_rx_link.sv
module i2c_rx_link
  import i2c_demux_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_pull_o
);
  link_state_e       state_q, state_d;
  logic [BCNT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              addr_ph_q, addr_ph_d;
  logic [BYTE_W-1:0] full_byte;
  logic              addr_hit;
  logic              last_bit;

  assign full_byte = {shift_q[BYTE_W-2:0], sda_i};
  assign addr_hit  = (full_byte[7:2] == DEV_ADDR[6:1]) &&
                     (full_byte[1] == strap_i) && !full_byte[0];
  assign last_bit  = (state_q == LNK_RX) && scl_rise_i &&
                     (bit_q == BCNT_W'(BYTE_W-1));

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    shift_d   = shift_q;
    addr_ph_d = addr_ph_q;
    if (start_i) begin
      state_d   = LNK_RX;
      bit_d     = '0;
      addr_ph_d = 1'b1;
    end else if (stop_i) begin
      state_d = LNK_IDLE;
    end else begin
      unique case (state_q)
        LNK_RX: begin
          if (scl_rise_i) begin
            shift_d = full_byte;
            bit_d   = bit_q + BCNT_W'(1);
            if (last_bit) begin
              if (!addr_ph_q || addr_hit) state_d = LNK_ACK_SETUP;
              else                        state_d = LNK_IDLE;
            end
          end
        end
        LNK_ACK_SETUP: if (scl_fall_i) state_d = LNK_ACK;
        LNK_ACK: begin
          if (scl_fall_i) begin
            state_d   = LNK_RX;
            bit_d     = '0;
            addr_ph_d = 1'b0;
          end
        end
        default: state_d = LNK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LNK_IDLE;
      bit_q     <= '0;
      shift_q   <= '0;
      addr_ph_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      shift_q   <= shift_d;
      addr_ph_q <= addr_ph_d;
    end
  end

  assign byte_stb_o = last_bit && !addr_ph_q && !start_i && !stop_i;
  assign byte_o     = full_byte;
  assign sda_pull_o = (state_q == LNK_ACK);
endmodule

// File: rtl/i2c_ctrl_router.sv
module i2c_ctrl_router
  import i2c_demux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              ram_valid_o,
  output logic [BYTE_W-1:0] ram_data_o
);
  route_state_e      st_q, st_d;
  logic              route_q, route_d;
  logic              cmd_v_d, ram_v_d;
  logic              emit;
  logic [BYTE_W-1:0] cmd_q, ram_q;

  assign emit    = byte_stb_i && (st_q != RT_CTRL);
  assign cmd_v_d = emit && !route_q;
  assign ram_v_d = emit && route_q;

  always_comb begin
    st_d    = st_q;
    route_d = route_q;
    if (start_i) begin
      st_d = RT_CTRL;
    end else if (byte_stb_i) begin
      unique case (st_q)
        RT_CTRL: begin
          route_d = byte_i[ROUTE_B];
          st_d    = byte_i[CHAIN_B] ? RT_SINGLE : RT_STREAM;
        end
        RT_SINGLE: st_d = RT_CTRL;
        default:   st_d = RT_STREAM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= RT_CTRL;
      route_q     <= 1'b0;
      cmd_valid_o <= 1'b0;
      ram_valid_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      route_q     <= route_d;
      cmd_valid_o <= cmd_v_d;
      ram_valid_o <= ram_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ram_q <= '0;
    end else begin
      if (cmd_v_d) cmd_q <= byte_i;
      if (ram_v_d) ram_q <= byte_i;
    end
  end

  assign cmd_data_o = cmd_q;
  assign ram_data_o = ram_q;
endmodule

// File: rtl/i2c_ctl_demux.sv
module i2c_ctl_demux
  import i2c_demux_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h3A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              ram_valid_o,
  output logic [BYTE_W-1:0] ram_data_o
);
  logic              scl_sync, sda_sync, scl_rise, scl_fall;
  logic              start_det, stop_det, byte_stb;
  logic [BYTE_W-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_o(scl_sync), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_sync), .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rx_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk, .rst_n, .strap_i(addr_sel_i), .sda_i(sda_sync),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .byte_stb_o(byte_stb), .byte_o(rx_byte), .sda_pull_o
  );

  i2c_ctrl_router u_router (
    .clk, .rst_n, .start_i(start_det),
    .byte_stb_i(byte_stb), .byte_i(rx_byte),
    .cmd_valid_o, .cmd_data_o, .ram_valid_o, .ram_data_o
  );
endmodule

// File: rtl/i2c_ctl_demux_chk.sv
module i2c_ctl_demux_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic start_det,
  input logic stop_det,
  input logic byte_stb,
  input logic sda_pull_o,
  input logic cmd_valid_o,
  input logic ram_valid_o
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && ram_valid_o));
  a_r9_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  a_r9_ram_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid_o |=> !ram_valid_o);
  a_r5_out_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || ram_valid_o) |-> $past(byte_stb));
  a_r10_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!cmd_valid_o && !ram_valid_o && !sda_pull_o));
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
  a_r12_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull_o != $past(sda_pull_o)) && !$past(start_det) && !$past(stop_det))
      |-> !scl_sync);
endmodule

bind i2c_ctl_demux i2c_ctl_demux_chk u_chk (.*);

// File: tb/i2c_ctl_demux_tb.sv
module i2c_ctl_demux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QT = 6;
  localparam int HT = 12;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o, cmd_valid_o, ram_valid_o;
  logic [7:0] cmd_data_o, ram_data_o;
  wire  sda_bus = sda_m & ~sda_pull_o;

  int n_chk = 0, n_fail = 0, strobe_cnt = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctl_demux #(.DEV_ADDR(7'h39)) u_dut (
    .clk, .rst_n, .addr_sel_i(strap), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o, .cmd_valid_o, .cmd_data_o, .ram_valid_o, .ram_data_o
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic push_exp(input bit is_ram, input logic [7:0] d, input string tag);
    exp_q.push_back({is_ram, d});
    tag_q.push_back(tag);
  endtask

  task automatic take_out(input bit is_ram, input logic [7:0] d);
    logic [8:0] e;
    string t;
    strobe_cnt++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9 unexpected strobe", {is_ram, d}, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e == {is_ram, d}, t, {is_ram, d}, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmd_valid_o) take_out(1'b0, cmd_data_o);
      if (ram_valid_o) take_out(1'b1, ram_data_o);
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(QT);
    scl_m = 1'b1; wait_clk(HT);
    sda_m = 1'b0; wait_clk(HT);
    scl_m = 1'b0; wait_clk(QT);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(QT);
    scl_m = 1'b1; wait_clk(HT);
    sda_m = 1'b1; wait_clk(HT);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(QT);
      scl_m = 1'b1; wait_clk(HT);
      scl_m = 1'b0; wait_clk(QT);
    end
    sda_m = 1'b1; wait_clk(QT);
    scl_m = 1'b1; wait_clk(HT/2);
    ack = sda_pull_o;
    check(ack == exp_ack, tag, ack, exp_ack);
    wait_clk(HT - HT/2);
    scl_m = 1'b0; wait_clk(QT);
  endtask

  task automatic check_drained(input string tag);
    wait_clk(20);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    int base;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    check(!cmd_valid_o && !ram_valid_o && !sda_pull_o, "R9 reset state",
          {cmd_valid_o, ram_valid_o, sda_pull_o}, 0);

    // R1 R7 R8: strap 0, stream of display data
    strap = 1'b0;
    bus_start();
    send_byte(8'h70, 1'b1, "R1 address ack strap0");
    send_byte(8'h40, 1'b1, "R8 control ack");
    push_exp(1'b1, 8'hA5, "R7 stream byte 1");
    send_byte(8'hA5, 1'b1, "R8 data ack");
    push_exp(1'b1, 8'h3C, "R7 stream byte 2");
    send_byte(8'h3C, 1'b1, "R8 data ack");
    bus_stop();
    check_drained("R7 stream delivered");

    // R6 R5: two commands each with own control byte
    bus_start();
    send_byte(8'h70, 1'b1, "R1 address ack");
    send_byte(8'h80, 1'b1, "R8 control ack");
    push_exp(1'b0, 8'h11, "R5 command 1");
    send_byte(8'h11, 1'b1, "R8 data ack");
    send_byte(8'h80, 1'b1, "R6 second control ack");
    push_exp(1'b0, 8'h22, "R6 command 2");
    send_byte(8'h22, 1'b1, "R8 data ack");
    bus_stop();
    check_drained("R6 chained commands delivered");

    // R4: low control bits set; streamed bytes that look like control bytes
    bus_start();
    send_byte(8'h70, 1'b1, "R1 address ack");
    send_byte(8'hBF, 1'b1, "R4 control ack");
    push_exp(1'b0, 8'hE0, "R4 command after 0xBF");
    send_byte(8'hE0, 1'b1, "R8 data ack");
    send_byte(8'h7F, 1'b1, "R4 control ack");
    push_exp(1'b1, 8'h80, "R7 ram 0x80 kept as data");
    send_byte(8'h80, 1'b1, "R8 data ack");
    push_exp(1'b1, 8'hC0, "R7 ram 0xC0 kept as data");
    send_byte(8'hC0, 1'b1, "R8 data ack");
    bus_stop();
    check_drained("R4 mixed sequence delivered");

    // R2: strap 1, address 0x70 no longer matches
    strap = 1'b1;
    base = strobe_cnt;
    bus_start();
    send_byte(8'h70, 1'b0, "R2 no address ack");
    send_byte(8'h40, 1'b0, "R2 no control ack");
    send_byte(8'h55, 1'b0, "R2 no data ack");
    bus_stop();
    wait_clk(20);
    check(strobe_cnt == base, "R2 no strobes", strobe_cnt - base, 0);

    // R1 with strap 1
    bus_start();
    send_byte(8'h72, 1'b1, "R1 address ack strap1");
    send_byte(8'h00, 1'b1, "R8 control ack");
    push_exp(1'b0, 8'h99, "R5 command strap1");
    send_byte(8'h99, 1'b1, "R8 data ack");
    bus_stop();
    check_drained("R1 strap1 delivered");

    // R3: read request ignored
    base = strobe_cnt;
    bus_start();
    send_byte(8'h73, 1'b0, "R3 read not acked");
    send_byte(8'h40, 1'b0, "R3 no ack after read");
    send_byte(8'h12, 1'b0, "R3 no ack after read");
    bus_stop();
    wait_clk(20);
    check(strobe_cnt == base, "R3 no strobes", strobe_cnt - base, 0);

    // R10: repeated start resets parser
    bus_start();
    send_byte(8'h72, 1'b1, "R1 address ack");
    send_byte(8'h40, 1'b1, "R8 control ack");
    push_exp(1'b1, 8'h5A, "R10 ram before restart");
    send_byte(8'h5A, 1'b1, "R8 data ack");
    bus_start();
    send_byte(8'h72, 1'b1, "R10 address after restart");
    send_byte(8'h00, 1'b1, "R10 control after restart");
    push_exp(1'b0, 8'h6B, "R10 command after restart");
    send_byte(8'h6B, 1'b1, "R8 data ack");
    bus_stop();
    check_drained("R10 restart delivered");

    // R11: bytes after stop without start
    base = strobe_cnt;
    wait_clk(QT);
    scl_m = 1'b0; wait_clk(QT);
    send_byte(8'h72, 1'b0, "R11 no ack after stop");
    send_byte(8'h40, 1'b0, "R11 no ack after stop");
    bus_stop();
    wait_clk(20);
    check(strobe_cnt == base, "R11 no strobes", strobe_cnt - base, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule